// File: doc/BRIEF.md
# Prioritised Memory Protection Checker

This block decides whether a single memory access may proceed. It takes a request address, a byte count, the wanted read/write/execute rights and a flag that says whether the requester runs in machine mode. It compares the request against a set of protection regions in parallel. Each region arrives from outside already decoded into an inclusive start and end address, a rights mask, a lock bit and an enable bit. The block does not hold region storage and does not decode region addresses.

The lowest-numbered region that touches the access decides the result. If that region holds the whole access, its rights apply. Machine mode bypasses the rights of regions that are not locked. If that region holds only one end of the access, the access fails outright. When no region touches the access, a default policy applies, which depends on the privilege mode and on a deny-unmatched control input. The verdict appears on registered outputs one cycle after the request.

Top module: `mpc_region_check`

## Requirements
- R1: Among enabled regions that hold both the first and the last byte of the access, the lowest-numbered one decides. Its number appears on `rsp_idx` and `rsp_kind` is 1 (region) when the access is granted.
- R2: If the lowest-numbered enabled region that touches the access holds exactly one of the first and last byte, the access is denied. The outputs are `rsp_kind` 0 (fail), `rsp_allow` 000 and `rsp_idx` set to that region. No higher-numbered region is consulted.
- R3: A region whose enable bit is 0 neither matches nor causes a partial-overlap denial.
- R4: On a full match in machine mode against a region whose lock bit is 0, the allowed mask is 111 (read, write, execute).
- R5: On a full match against a locked region, or from a non-machine mode, the allowed mask is the region's rights. Within a 3-bit rights field, bit 2 is read, bit 1 is write and bit 0 is execute.
- R6: The access is granted only if every requested rights bit is set in the allowed mask. A denied full match reports kind 0 and the region's allowed mask.
- R7: With no match and the deny-unmatched control low, a machine-mode access is granted with mask 111 and kind 2 (default).
- R8: With no match and the deny-unmatched control low, a non-machine access is denied (kind 0, mask 000) if any region is enabled. If no region is enabled, it is granted with mask 111 and kind 2.
- R9: With the deny-unmatched control high, an access that matches no region is denied in every mode, with kind 0 and mask 000.
- R10: The last byte is the address plus the size minus one, and a size of 0 counts as one byte. All bound comparisons are unsigned and inclusive at both ends.
- R11: `rsp_valid` follows `req_valid` with one cycle of delay. The verdict outputs update only in the cycle after a valid request and hold their value otherwise.
- R12: After reset, `rsp_valid`, `rsp_grant`, `rsp_allow`, `rsp_kind` and `rsp_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | First byte address of the access |
| req_size | input | SW | Access length in bytes (0 treated as 1) |
| req_perm | input | 3 | Wanted rights: bit 2 read, bit 1 write, bit 0 execute |
| req_mmode | input | 1 | Requester runs in machine mode |
| deny_unmatched | input | 1 | Deny unmatched accesses in every mode |
| rgn_lo | input | NREG*AW | Inclusive start address per region, region i at bits [i*AW +: AW] |
| rgn_hi | input | NREG*AW | Inclusive end address per region |
| rgn_perm | input | NREG*3 | Rights per region, region i at bits [i*3 +: 3] |
| rgn_lock | input | NREG | Lock bit per region |
| rgn_on | input | NREG | Enable bit per region |
| rsp_valid | output | 1 | Verdict registered from a request of the previous cycle |
| rsp_grant | output | 1 | Access allowed |
| rsp_allow | output | 3 | Allowed rights mask |
| rsp_kind | output | 2 | 0 fail, 1 region granted, 2 default granted |
| rsp_idx | output | IDXW | Deciding region number (0 when the default policy decided) |

## Verification
A corrupted priority order shows up on `rsp_idx` one cycle after a request covered by two regions, because the higher-numbered region is reported instead. A broken overlap test shows up as a grant for an access that straddles a region edge. A wrong lock or mode term shows up as an allowed mask of 111 where the region's own rights should appear, or the reverse. A fault in the default path shows up in `rsp_kind`, which reads 2 where 0 is due. Each of these faults is visible on the first response after the triggering request, since the verdict comes from a single register stage.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef logic [2:0] rwx_t;

    localparam rwx_t RWX_ALL  = 3'b111;
    localparam rwx_t RWX_NONE = 3'b000;

    typedef enum logic [1:0] {
        KIND_FAIL    = 2'd0,
        KIND_REGION  = 2'd1,
        KIND_DEFAULT = 2'd2
    } verdict_kind_e;

    typedef struct packed {
        logic          grant;
        rwx_t          allow;
        verdict_kind_e kind;
    } verdict_t;

    typedef struct packed {
        logic full;
        logic partial;
    } touch_t;

    function automatic logic rwx_covers(rwx_t allowed, rwx_t want);
        return (want & ~allowed) == RWX_NONE;
    endfunction

endpackage

// File: rtl/mpc_span.sv
module mpc_span #(
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic [AW-1:0] first_addr,
    input  logic [SW-1:0] size,
    output logic [AW-1:0] last_addr
);
    logic [AW-1:0] size_ext;
    logic [AW-1:0] extra;

    always_comb begin
        size_ext = AW'(size);
        extra    = (size == '0) ? '0 : size_ext - AW'(1);
        last_addr = first_addr + extra;
    end
endmodule

// File: rtl/mpc_region_cmp.sv
module mpc_region_cmp
    import mpc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          enabled,
    output touch_t        touch
);
    logic first_in;
    logic last_in;

    always_comb begin
        first_in      = (first_addr >= lo) && (first_addr <= hi);
        last_in       = (last_addr  >= lo) && (last_addr  <= hi);
        touch.full    = enabled && first_in && last_in;
        touch.partial = enabled && (first_in ^ last_in);
    end
endmodule

// File: rtl/mpc_first_pick.sv
module mpc_first_pick #(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic [N-1:0]    hit,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/mpc_verdict.sv
module mpc_verdict
    import mpc_pkg::*;
(
    input  logic     any_hit,
    input  logic     sel_partial,
    input  logic     sel_lock,
    input  rwx_t     sel_perm,
    input  logic     any_active,
    input  logic     mmode,
    input  logic     deny_unmatched,
    input  rwx_t     want,
    output verdict_t verdict
);
    always_comb begin
        verdict.grant = 1'b0;
        verdict.allow = RWX_NONE;
        verdict.kind  = KIND_FAIL;
        if (any_hit) begin
            if (!sel_partial) begin
                verdict.allow = (mmode && !sel_lock) ? RWX_ALL : sel_perm;
                verdict.grant = rwx_covers(verdict.allow, want);
                verdict.kind  = verdict.grant ? KIND_REGION : KIND_FAIL;
            end
        end else if (!deny_unmatched && (mmode || !any_active)) begin
            verdict.allow = RWX_ALL;
            verdict.grant = 1'b1;
            verdict.kind  = KIND_DEFAULT;
        end
    end
endmodule

// File: rtl/mpc_region_check.sv
module mpc_region_check
    import mpc_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32,
    parameter int SW   = 4,
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [AW-1:0]      req_addr,
    input  logic [SW-1:0]      req_size,
    input  logic [2:0]         req_perm,
    input  logic               req_mmode,
    input  logic               deny_unmatched,
    input  logic [NREG*AW-1:0] rgn_lo,
    input  logic [NREG*AW-1:0] rgn_hi,
    input  logic [NREG*3-1:0]  rgn_perm,
    input  logic [NREG-1:0]    rgn_lock,
    input  logic [NREG-1:0]    rgn_on,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic [2:0]         rsp_allow,
    output logic [1:0]         rsp_kind,
    output logic [IDXW-1:0]    rsp_idx
);
    logic [AW-1:0]   last_addr;
    touch_t          touch_a [NREG];
    rwx_t            perm_a  [NREG];
    logic [NREG-1:0] hit_vec;
    logic [NREG-1:0] partial_vec;
    logic            any_hit;
    logic [IDXW-1:0] sel_idx;
    verdict_t        verdict;

    mpc_span #(.AW(AW), .SW(SW)) u_span (
        .first_addr (req_addr),
        .size       (req_size),
        .last_addr  (last_addr)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        mpc_region_cmp #(.AW(AW)) u_cmp (
            .first_addr (req_addr),
            .last_addr  (last_addr),
            .lo         (rgn_lo[g*AW +: AW]),
            .hi         (rgn_hi[g*AW +: AW]),
            .enabled    (rgn_on[g]),
            .touch      (touch_a[g])
        );
        assign perm_a[g]      = rgn_perm[g*3 +: 3];
        assign hit_vec[g]     = touch_a[g].full | touch_a[g].partial;
        assign partial_vec[g] = touch_a[g].partial;
    end

    mpc_first_pick #(.N(NREG), .IDXW(IDXW)) u_pick (
        .hit (hit_vec),
        .any (any_hit),
        .idx (sel_idx)
    );

    mpc_verdict u_verdict (
        .any_hit        (any_hit),
        .sel_partial    (partial_vec[sel_idx]),
        .sel_lock       (rgn_lock[sel_idx]),
        .sel_perm       (perm_a[sel_idx]),
        .any_active     (|rgn_on),
        .mmode          (req_mmode),
        .deny_unmatched (deny_unmatched),
        .want           (req_perm),
        .verdict        (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_allow <= RWX_NONE;
            rsp_kind  <= KIND_FAIL;
            rsp_idx   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_grant <= verdict.grant;
                rsp_allow <= verdict.allow;
                rsp_kind  <= verdict.kind;
                rsp_idx   <= any_hit ? sel_idx : '0;
            end
        end
    end
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
    parameter int NREG = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [2:0]      req_perm,
    input logic            req_mmode,
    input logic            deny_unmatched,
    input logic [NREG-1:0] rgn_on,
    input logic            rsp_valid,
    input logic            rsp_grant,
    input logic [2:0]      rsp_allow,
    input logic [1:0]      rsp_kind
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_grant) && $stable(rsp_allow) && $stable(rsp_kind)));

    a_r6_grant_subset: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_grant || (($past(req_perm) & ~rsp_allow) == 3'b000)));

    a_r6_grant_kind: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_grant == (rsp_kind != 2'd0)));

    a_r9_no_default: assert property (@(posedge clk) disable iff (rst)
        (req_valid && deny_unmatched) |=> (rsp_kind != 2'd2));

    a_r8_user_no_default: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_mmode && (rgn_on != '0)) |=> (rsp_kind != 2'd2));

    a_r3_none_enabled: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (rgn_on == '0)) |=> (rsp_kind != 2'd1));
endmodule

bind mpc_region_check mpc_checker #(.NREG(NREG)) u_mpc_checker (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_perm       (req_perm),
    .req_mmode      (req_mmode),
    .deny_unmatched (deny_unmatched),
    .rgn_on         (rgn_on),
    .rsp_valid      (rsp_valid),
    .rsp_grant      (rsp_grant),
    .rsp_allow      (rsp_allow),
    .rsp_kind       (rsp_kind)
);

// File: tb/tb_mpc_region_check.sv
`timescale 1ns/1ps
module tb_mpc_region_check;
    localparam int NREG = 8;
    localparam int AW   = 32;
    localparam int SW   = 4;
    localparam int IDXW = 3;

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid;
    logic [AW-1:0]      req_addr;
    logic [SW-1:0]      req_size;
    logic [2:0]         req_perm;
    logic               req_mmode;
    logic               deny_unmatched;
    logic [NREG*AW-1:0] rgn_lo;
    logic [NREG*AW-1:0] rgn_hi;
    logic [NREG*3-1:0]  rgn_perm;
    logic [NREG-1:0]    rgn_lock;
    logic [NREG-1:0]    rgn_on;
    logic               rsp_valid;
    logic               rsp_grant;
    logic [2:0]         rsp_allow;
    logic [1:0]         rsp_kind;
    logic [IDXW-1:0]    rsp_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mpc_region_check #(.NREG(NREG), .AW(AW), .SW(SW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
        .deny_unmatched(deny_unmatched), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi),
        .rgn_perm(rgn_perm), .rgn_lock(rgn_lock), .rgn_on(rgn_on),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_allow(rsp_allow),
        .rsp_kind(rsp_kind), .rsp_idx(rsp_idx)
    );

    task automatic chk(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic clear_regions();
        rgn_lo = '0; rgn_hi = '0; rgn_perm = '0; rgn_lock = '0; rgn_on = '0;
    endtask

    task automatic set_region(int i, logic [AW-1:0] lo, logic [AW-1:0] hi,
                              logic [2:0] perm, logic lock);
        rgn_lo[i*AW +: AW] = lo;
        rgn_hi[i*AW +: AW] = hi;
        rgn_perm[i*3 +: 3] = perm;
        rgn_lock[i]        = lock;
        rgn_on[i]          = 1'b1;
    endtask

    // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
    task automatic access(logic [AW-1:0] a, logic [SW-1:0] s, logic [2:0] p, logic mm);
        @(negedge clk);
        req_addr = a; req_size = s; req_perm = p; req_mmode = mm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(string req, int grant, int allow, int kind, int idx);
        chk(req, "valid", int'(rsp_valid), 1);
        chk(req, "grant", int'(rsp_grant), grant);
        chk(req, "allow", int'(rsp_allow), allow);
        chk(req, "kind",  int'(rsp_kind),  kind);
        chk(req, "idx",   int'(rsp_idx),   idx);
    endtask

    task automatic t_reset();
        chk("R12", "valid", int'(rsp_valid), 0);
        chk("R12", "grant", int'(rsp_grant), 0);
        chk("R12", "allow", int'(rsp_allow), 0);
        chk("R12", "kind",  int'(rsp_kind),  0);
        chk("R12", "idx",   int'(rsp_idx),   0);
    endtask

    task automatic t_priority();
        clear_regions();
        set_region(0, 32'h100, 32'h1FF, 3'b100, 1'b0);
        set_region(1, 32'h000, 32'hFFF, 3'b111, 1'b0);
        access(32'h150, 4, 3'b100, 1'b0);
        expect_rsp("R1", 1, 3'b100, 1, 0);
        access(32'h150, 4, 3'b010, 1'b0);
        expect_rsp("R6", 0, 3'b100, 0, 0);
        access(32'h800, 4, 3'b011, 1'b0);
        expect_rsp("R1", 1, 3'b111, 1, 1);
    endtask

    task automatic t_partial();
        clear_regions();
        set_region(0, 32'h100, 32'h1FF, 3'b111, 1'b0);
        set_region(1, 32'h000, 32'hFFF, 3'b111, 1'b0);
        access(32'h1FE, 4, 3'b100, 1'b1);
        expect_rsp("R2", 0, 0, 0, 0);
        access(32'h0FE, 4, 3'b100, 1'b0);
        expect_rsp("R2", 0, 0, 0, 0);
    endtask

    task automatic t_off();
        clear_regions();
        set_region(0, 32'h100, 32'h1FF, 3'b000, 1'b1);
        set_region(1, 32'h000, 32'hFFF, 3'b101, 1'b0);
        rgn_on[0] = 1'b0;
        access(32'h150, 4, 3'b100, 1'b0);
        expect_rsp("R3", 1, 3'b101, 1, 1);
        access(32'h1FE, 4, 3'b001, 1'b0);
        expect_rsp("R3", 1, 3'b101, 1, 1);
    endtask

    task automatic t_mode_lock();
        clear_regions();
        set_region(0, 32'h2000, 32'h2FFF, 3'b100, 1'b0);
        access(32'h2000, 8, 3'b011, 1'b1);
        expect_rsp("R4", 1, 3'b111, 1, 0);
        access(32'h2000, 8, 3'b010, 1'b0);
        expect_rsp("R5", 0, 3'b100, 0, 0);
        rgn_lock[0] = 1'b1;
        access(32'h2000, 8, 3'b010, 1'b1);
        expect_rsp("R5", 0, 3'b100, 0, 0);
        access(32'h2000, 8, 3'b100, 1'b1);
        expect_rsp("R5", 1, 3'b100, 1, 0);
    endtask

    task automatic t_default();
        clear_regions();
        deny_unmatched = 1'b0;
        access(32'h40, 1, 3'b111, 1'b0);
        expect_rsp("R8", 1, 3'b111, 2, 0);
        set_region(2, 32'h5000, 32'h5FFF, 3'b111, 1'b0);
        access(32'h40, 1, 3'b100, 1'b0);
        expect_rsp("R8", 0, 0, 0, 0);
        access(32'h40, 1, 3'b111, 1'b1);
        expect_rsp("R7", 1, 3'b111, 2, 0);
        deny_unmatched = 1'b1;
        access(32'h40, 1, 3'b100, 1'b1);
        expect_rsp("R9", 0, 0, 0, 0);
        clear_regions();
        access(32'h40, 1, 3'b100, 1'b0);
        expect_rsp("R9", 0, 0, 0, 0);
        deny_unmatched = 1'b0;
    endtask

    task automatic t_bounds();
        clear_regions();
        set_region(0, 32'h100, 32'h103, 3'b001, 1'b1);
        set_region(7, 32'hF000, 32'hF0FF, 3'b111, 1'b1);
        access(32'h100, 4, 3'b001, 1'b0);
        expect_rsp("R10", 1, 3'b001, 1, 0);
        access(32'h100, 0, 3'b001, 1'b0);
        expect_rsp("R10", 1, 3'b001, 1, 0);
        access(32'h103, 1, 3'b001, 1'b0);
        expect_rsp("R10", 1, 3'b001, 1, 0);
        access(32'h100, 5, 3'b001, 1'b0);
        expect_rsp("R10", 0, 0, 0, 0);
        access(32'h0FF, 1, 3'b001, 1'b1);
        expect_rsp("R10", 1, 3'b111, 2, 0);
        access(32'h104, 1, 3'b001, 1'b1);
        expect_rsp("R10", 1, 3'b111, 2, 0);
        access(32'hF0F0, 15, 3'b010, 1'b0);
        expect_rsp("R10", 1, 3'b111, 1, 7);
    endtask

    task automatic t_hold();
        clear_regions();
        set_region(3, 32'h300, 32'h3FF, 3'b110, 1'b0);
        access(32'h300, 2, 3'b010, 1'b0);
        expect_rsp("R11", 1, 3'b110, 1, 3);
        req_addr = 32'h9000; req_perm = 3'b001;
        @(negedge clk);
        chk("R11", "valid idle", int'(rsp_valid), 0);
        chk("R11", "grant held", int'(rsp_grant), 1);
        chk("R11", "allow held", int'(rsp_allow), 3'b110);
        chk("R11", "idx held",   int'(rsp_idx),   3);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_perm = '0; req_mmode = 1'b0; deny_unmatched = 1'b0;
        clear_regions();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_priority();
        t_partial();
        t_off();
        t_mode_lock();
        t_default();
        t_bounds();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule